// File: doc/BRIEF.md
# Register-Programmable Watchdog Timer

This block is a watchdog timer with a small memory-mapped register bus. Software sets up two 4-bit period selects. One period is used for the first countdown after enabling. The other is used for every later reload. Software then enables the counter and must write a fixed restart key on a regular schedule. If no valid restart arrives before the down-counter reaches zero, the block raises a system-reset request for a fixed number of cycles. It then reloads the counter and keeps counting.

The bus has a single cycle for each transfer. A write takes effect on the clock edge where the write strobe is high. Read data is combinational from the address while the read strobe is high, and it is zero at all other times. Once software sets the enable, it cannot clear it. Only the active-low hardware reset returns the block to the disabled state.

Top module: `wdog_timer`

## Requirements
- R1: After reset the enable is 0, both period selects are 0, the live count reads 0 and `rst_req` is low.
- R2: Register map by byte offset. 0x00 holds the enable in bit 0. 0x04 holds the reload select in bits 3:0 and the initial select in bits 7:4. 0x08 returns the live count. 0x0C is the restart register and reads as 0. Unmapped offsets and unused bits read as 0.
- R3: A select value s (0..15) gives a period of 2^(BASE_EXP+s) cycles, with BASE_EXP = 16 by default.
- R4: A write of 1 to enable bit 0 while the block is disabled sets the enable. In the next cycle the count equals the initial-select period. After that it falls by exactly one each cycle.
- R5: Writing 0 to the enable register while the block is enabled leaves the enable set and the count running.
- R6: While enabled, a write of exactly 0x00000076 to offset 0x0C sets the count to the reload-select period in the next cycle.
- R7: A write to offset 0x0C with any other 32-bit value leaves the count unchanged.
- R8: While disabled, the count is held at 0 and writes of the key to offset 0x0C have no effect.
- R9: When the enabled count is 0, `rst_req` rises on the next edge and stays high for PULSE_LEN (default 8) cycles. While it is high the count reads 0 and restart writes are ignored. On the edge where it falls, the count loads the reload-select period and counting resumes.
- R10: Writes to offset 0x08 have no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_wr | input | 1 | Write strobe, one transfer per high cycle |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Read data, zero when no read is active |
| rst_req | output | 1 | System-reset request pulse on expiry |

## Verification
Some properties are checked by assertions on every cycle:
- the enable never falls outside reset;
- the count sits at zero whenever the block is disabled;
- an idle enabled count drops by exactly one per cycle;
- the reset request rises only after a zero count, starts at its full length, and hands the counter the reload period as it ends;
- the decoded period is always a single power of two.

Other behaviour shows only in the bench scenarios:
- the exact cycle at which each period is loaded;
- rejection of near-miss keys and of writes to the count register;
- masking of unused bits;
- the position of the request pulse relative to the last restart.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned OFS_CTRL  = 32'h00;
  localparam int unsigned OFS_RANGE = 32'h04;
  localparam int unsigned OFS_COUNT = 32'h08;
  localparam int unsigned OFS_KICK  = 32'h0C;
  localparam int unsigned KICK_KEY  = 32'h76;

  // Period length in cycles for a select value: 2^(base+sel).
  function automatic logic [63:0] span_of(input int unsigned base, input int unsigned sel);
    return 64'd1 << (base + sel);
  endfunction
endpackage

// File: rtl/wdt_span_dec.sv
module wdt_span_dec #(
  parameter int unsigned SEL_W    = 4,
  parameter int unsigned BASE_EXP = 16,
  parameter int unsigned CNT_W    = 32
) (
  input  logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] span
);
  import wdt_pkg::*;
  localparam int unsigned NSEL = 1 << SEL_W;

  logic [CNT_W-1:0] tbl [NSEL];

  for (genvar g = 0; g < NSEL; g++) begin : g_span
    assign tbl[g] = CNT_W'(span_of(BASE_EXP, g));
  end

  assign span = tbl[sel];
endmodule

// File: rtl/wdt_regfile.sv
module wdt_regfile #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SEL_W  = 4,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rdata,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              en_o,
  output logic [SEL_W-1:0]  top_sel_o,
  output logic [SEL_W-1:0]  init_sel_o,
  output logic              start_o,
  output logic              kick_o
);
  import wdt_pkg::*;

  logic hit_ctrl, hit_range, hit_count, hit_kick;
  logic key_ok;
  logic en_q;
  logic [SEL_W-1:0] top_q, init_q;

  assign hit_ctrl  = addr == ADDR_W'(OFS_CTRL);
  assign hit_range = addr == ADDR_W'(OFS_RANGE);
  assign hit_count = addr == ADDR_W'(OFS_COUNT);
  assign hit_kick  = addr == ADDR_W'(OFS_KICK);
  assign key_ok    = wdata == DATA_W'(KICK_KEY);

  // Enable event: only a disabled block can be started.
  assign start_o = wr_en && hit_ctrl && wdata[0] && !en_q;
  // Restart event: exact key, enabled block.
  assign kick_o  = wr_en && hit_kick && key_ok && en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      top_q  <= '0;
      init_q <= '0;
    end else begin
      if (start_o) en_q <= 1'b1;
      if (wr_en && hit_range) begin
        top_q  <= wdata[SEL_W-1:0];
        init_q <= wdata[2*SEL_W-1:SEL_W];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (hit_ctrl)       rdata[0] = en_q;
      else if (hit_range) rdata[2*SEL_W-1:0] = {init_q, top_q};
      else if (hit_count) rdata = DATA_W'(cnt_i);
    end
  end

  assign en_o       = en_q;
  assign top_sel_o  = top_q;
  assign init_sel_o = init_q;

  // R5
  enable_lock_chk: assert property (@(posedge clk) disable iff (!rst_n) !$fell(en_q))
    else $error("enable dropped without reset");
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned PULSE_LEN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             start,
  input  logic             kick,
  input  logic [CNT_W-1:0] init_span,
  input  logic [CNT_W-1:0] top_span,
  output logic [CNT_W-1:0] cnt,
  output logic             rst_req
);
  localparam int unsigned PW = $clog2(PULSE_LEN + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [PW-1:0]    pulse_q;
  logic in_pulse, kick_take, at_zero, expire_ev, pulse_end;

  assign in_pulse  = pulse_q != '0;
  assign kick_take = kick && !in_pulse;
  assign at_zero   = cnt_q == '0;
  assign expire_ev = en && !start && !in_pulse && !kick_take && at_zero;
  assign pulse_end = pulse_q == PW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= '0;
    end else if (start) begin
      cnt_q   <= init_span;
      pulse_q <= '0;
    end else if (!en) begin
      cnt_q   <= '0;
      pulse_q <= '0;
    end else if (in_pulse) begin
      pulse_q <= pulse_q - PW'(1);
      if (pulse_end) cnt_q <= top_span;
    end else if (kick_take) begin
      cnt_q <= top_span;
    end else if (expire_ev) begin
      pulse_q <= PW'(PULSE_LEN);
    end else begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign cnt     = cnt_q;
  assign rst_req = in_pulse;

  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) !en |-> cnt_q == '0)
    else $error("count nonzero while disabled");
  // R4
  tick_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !start && !in_pulse && !kick_take && !at_zero) |=> cnt_q == $past(cnt_q) - CNT_W'(1))
    else $error("count did not step down by one");
  // R9
  req_after_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(at_zero))
    else $error("reset request without zero count");
  // R9
  req_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> pulse_q == PW'(PULSE_LEN))
    else $error("reset request started short");
  // R9
  req_end_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_req) |-> cnt_q == $past(top_span))
    else $error("no reload after reset request");
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned SEL_W     = 4,
  parameter int unsigned BASE_EXP  = 16,
  parameter int unsigned PULSE_LEN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rst_req
);
  localparam int unsigned CNT_W = BASE_EXP + (1 << SEL_W);

  logic             en_w, start_w, kick_w;
  logic [SEL_W-1:0] top_sel_w, init_sel_w;
  logic [CNT_W-1:0] top_span_w, init_span_w, cnt_w;

  wdt_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata),
    .wr_en(bus_wr), .rd_en(bus_rd), .rdata(bus_rdata), .cnt_i(cnt_w),
    .en_o(en_w), .top_sel_o(top_sel_w), .init_sel_o(init_sel_w),
    .start_o(start_w), .kick_o(kick_w)
  );

  wdt_span_dec #(.SEL_W(SEL_W), .BASE_EXP(BASE_EXP), .CNT_W(CNT_W)) u_top_dec (
    .sel(top_sel_w), .span(top_span_w)
  );

  wdt_span_dec #(.SEL_W(SEL_W), .BASE_EXP(BASE_EXP), .CNT_W(CNT_W)) u_init_dec (
    .sel(init_sel_w), .span(init_span_w)
  );

  wdt_countdown #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en_w), .start(start_w), .kick(kick_w),
    .init_span(init_span_w), .top_span(top_span_w), .cnt(cnt_w), .rst_req(rst_req)
  );

  // R3
  span_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_w |-> ($countones(top_span_w) == 1 && $countones(init_span_w) == 1))
    else $error("period decode not a power of two");
endmodule

// File: tb/wdog_timer_tb_top.sv
module wdog_timer_tb_top;
  localparam int unsigned BEXP  = 4;
  localparam int unsigned PLEN  = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        rst_req;

  int total = 0;
  int bad = 0;
  int ecnt = 0;
  int wr_edge = 0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sbq[$];

  wdog_timer #(.BASE_EXP(BEXP), .PULSE_LEN(PLEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .rst_req(rst_req)
  );

  always #5 clk = ~clk;
  always @(posedge clk) ecnt <= ecnt + 1;

  function automatic int span(input int sel);
    return 1 << (BEXP + sel);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected read data as each read completes.
  always @(negedge clk) begin
    if (bus_rd) begin
      if (sbq.size() == 0) check("scoreboard-empty", 32'd1, 32'd0);
      else begin
        item_t it;
        it = sbq.pop_front();
        check(it.tag, bus_rdata, it.exp);
      end
    end
  end

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    wr_edge = ecnt + 1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, input logic [31:0] exp, input string tag);
    item_t it;
    @(posedge clk); #1;
    it.exp = exp; it.tag = tag;
    sbq.push_back(it);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); #1;
    bus_rd = 1'b0;
  endtask

  // Count read: n loaded on edge e, one less on each later edge.
  task automatic read_count(input int n, input int e, input string tag);
    item_t it;
    @(posedge clk); #1;
    it.exp = 32'(n - (ecnt - e)); it.tag = tag;
    sbq.push_back(it);
    bus_rd = 1'b1; bus_addr = 8'h08;
    @(negedge clk); #1;
    bus_rd = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int e;
    int n;
    int highs;
    int first_hi;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    check("R1 rst_req", {31'd0, rst_req}, 32'd0);
    bus_read(8'h00, 32'd0, "R1 ctrl");
    bus_read(8'h04, 32'd0, "R1 range");
    bus_read(8'h08, 32'd0, "R1 count");

    // R8 disabled: key ignored, count stays zero
    bus_write(8'h0C, 32'h76);
    bus_read(8'h08, 32'd0, "R8 count after key while disabled");
    bus_read(8'h00, 32'd0, "R8 ctrl stays clear");

    // R2 map, unused bits, unmapped offsets
    bus_write(8'h04, 32'hFFFF_FF21);
    bus_read(8'h04, 32'h21, "R2 range masked");
    bus_read(8'h10, 32'd0, "R2 unmapped");
    bus_read(8'h0C, 32'd0, "R2 restart reads zero");

    // R4 enable loads initial select (2) period
    bus_write(8'h00, 32'h1);
    e = wr_edge; n = span(2);
    read_count(n, e, "R4 initial load");
    read_count(n, e, "R4 counting down");
    bus_read(8'h00, 32'h1, "R2 ctrl enabled");

    // R5 enable lock
    bus_write(8'h00, 32'h0);
    bus_read(8'h00, 32'h1, "R5 enable held");
    read_count(n, e, "R5 still counting");

    // R7 wrong keys
    bus_write(8'h0C, 32'h77);
    read_count(n, e, "R7 key 0x77 ignored");
    bus_write(8'h0C, 32'h176);
    read_count(n, e, "R7 key 0x176 ignored");

    // R10 count register not writable
    bus_write(8'h08, 32'h5);
    read_count(n, e, "R10 count write ignored");

    // R6 good key reloads from reload select (1)
    bus_write(8'h0C, 32'h76);
    e = wr_edge; n = span(1);
    read_count(n, e, "R6 reload R3 span");

    // reload select -> 0 for the post-expiry reload
    bus_write(8'h04, 32'h20);

    // R9 expiry: sample 1ns after each edge
    highs = 0; first_hi = -1;
    while (ecnt < e + n + 12) begin
      item_t it;
      int k;
      @(posedge clk); #1;
      k = ecnt;
      if (k <= e + n) it.exp = 32'(n - (k - e));
      else if (k < e + n + 1 + PLEN) it.exp = 32'd0;
      else it.exp = 32'(span(0) - (k - (e + n + 1 + PLEN)));
      it.tag = "R9 count around expiry";
      sbq.push_back(it);
      bus_rd = 1'b1; bus_addr = 8'h08;
      if (k == e + n + 3) begin
        bus_wr = 1'b1; bus_wdata = 32'h76;
      end else bus_wr = 1'b0;
      if (rst_req) begin
        highs++;
        if (first_hi < 0) first_hi = k - e;
      end
      @(negedge clk);
    end
    #1 bus_rd = 1'b0; bus_wr = 1'b0;
    check("R9 request length", 32'(highs), 32'(PLEN));
    check("R9 request start", 32'(first_hi), 32'(n + 1));

    // R3 R6 reload select 0 gives shortest period
    bus_write(8'h0C, 32'h76);
    e = wr_edge;
    read_count(span(0), e, "R3 shortest span");
    check("R9 request low after pulse", {31'd0, rst_req}, 32'd0);

    repeat (2) @(posedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule